// File: doc/BRIEF.md
# Multicore Inter-Processor Interrupt Unit

This unit lets the cores of a small cluster interrupt one another. Each core reaches it through one of several command ports. Every port carries a valid strobe, an 8-bit opcode, the index of the issuing core and a 16-bit parameter. A core can raise an interrupt at another core, ask whether a target already has one waiting, learn which cores are behind its own waiting interrupt, and then acknowledge those senders one at a time.

For every target core the unit keeps one pending bit per possible sender. If several senders raise the same target before it responds, their requests merge into a single level interrupt line toward that target. That line stays high until each sender bit has been acknowledged. Results of status and source queries appear in a per-port readback register that holds its value between queries.

Top module: `ipi_unit`

## Requirements
- R1: After reset every interrupt output is low and every readback register is zero.
- R2: A raise command (opcode 0x01) from core c with target parameter t, where t differs from c and is below the core count, sets the pending bit of sender c at target t, and irq_o[t] is high from the cycle after the command.
- R3: A raise command whose target equals the issuing core changes no pending bit and no interrupt output.
- R4: Raises from different senders toward one target merge into one asserted line, and the pending state records every sender.
- R5: A status command (opcode 0x02) with target t loads the port's readback register on the next cycle with bit 0 equal to 1 when any sender is pending at t, and all other bits 0.
- R6: A source command (opcode 0x03) loads the port's readback register on the next cycle with bit s set exactly when sender s is pending at the issuing core (value 1, 2, 4, 8 for cores 0 to 3), and all bits from NUM_CORES upward 0.
- R7: An acknowledge command (opcode 0x04) with sender parameter s clears only sender s's bit at the issuing core, and irq_o of that core stays high while any other sender bit is still set.
- R8: A port's readback register changes only on a status or source command issued on that port, and keeps its value otherwise.
- R9: When a raise and an acknowledge address the same sender and target pair in the same cycle, the pending bit is set afterwards.
- R10: A command whose issuing core index is not below NUM_CORES is ignored. A raise or acknowledge whose parameter is not below NUM_CORES, and any opcode other than 0x01 to 0x04, change nothing. A status command whose target parameter is out of range loads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | NUM_PORTS | Command strobe, one bit per port |
| cmd_op | input | NUM_PORTS*8 | Opcode per port |
| cmd_core | input | NUM_PORTS*ID_W | Index of the core issuing on each port |
| cmd_param | input | NUM_PORTS*PARAM_W | Target or sender index per port |
| rdback | output | NUM_PORTS*DATA_W | Readback register per port |
| irq_o | output | NUM_CORES | Level interrupt line per core |

## Verification
The hardest case to reach is the collision of a raise and an acknowledge on one sender/target pair in the same cycle. It needs two ports that name matching cores and parameters in the same clock. Directed sequences create it both with the bit already set and with it clear. Long random runs over both ports then mix merged senders, partial acknowledges and out-of-range indices while a bench model tracks the whole pending matrix.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [7:0] {
    IPI_NOP    = 8'h00,
    IPI_RAISE  = 8'h01,
    IPI_STATUS = 8'h02,
    IPI_SOURCE = 8'h03,
    IPI_ACK    = 8'h04
  } ipi_op_e;

  // Flat position of the pending bit for (target, sender)
  function automatic int pair_index(input int tgt, input int src, input int n);
    return tgt * n + src;
  endfunction

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode #(
  parameter int NUM_CORES = 4,
  parameter int ID_W      = 4,
  parameter int PARAM_W   = 16
) (
  input  logic                           valid,
  input  logic [7:0]                     op,
  input  logic [ID_W-1:0]                core,
  input  logic [PARAM_W-1:0]             param,
  output logic [NUM_CORES*NUM_CORES-1:0] set_vec,
  output logic [NUM_CORES*NUM_CORES-1:0] clr_vec,
  output logic                           status_hit,
  output logic                           source_hit,
  output logic [NUM_CORES-1:0]           issuer_oh,
  output logic [NUM_CORES-1:0]           param_oh
);
  import ipi_pkg::*;

  function automatic logic [NUM_CORES-1:0] core_oh(input logic [ID_W-1:0] idx);
    logic [NUM_CORES-1:0] r;
    for (int i = 0; i < NUM_CORES; i++) r[i] = (32'(idx) == i);
    return r;
  endfunction

  function automatic logic [NUM_CORES-1:0] param_to_oh(input logic [PARAM_W-1:0] idx);
    logic [NUM_CORES-1:0] r;
    for (int i = 0; i < NUM_CORES; i++) r[i] = (32'(idx) == i);
    return r;
  endfunction

  logic go, is_raise, is_ack;

  assign issuer_oh  = core_oh(core);
  assign param_oh   = param_to_oh(param);
  assign go         = valid & (|issuer_oh);
  assign is_raise   = go & (op == IPI_RAISE);
  assign is_ack     = go & (op == IPI_ACK);
  assign status_hit = go & (op == IPI_STATUS);
  assign source_hit = go & (op == IPI_SOURCE);

  for (genvar t = 0; t < NUM_CORES; t++) begin : g_tgt
    for (genvar s = 0; s < NUM_CORES; s++) begin : g_src
      localparam int IDX = pair_index(t, s, NUM_CORES);
      if (t != s) begin : g_cross
        assign set_vec[IDX] = is_raise & param_oh[t] & issuer_oh[s];
      end else begin : g_self
        assign set_vec[IDX] = 1'b0;
      end
      assign clr_vec[IDX] = is_ack & issuer_oh[t] & param_oh[s];
    end
  end

endmodule

// File: rtl/ipi_pend_matrix.sv
module ipi_pend_matrix #(
  parameter int NUM_CORES = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CORES*NUM_CORES-1:0] set_all,
  input  logic [NUM_CORES*NUM_CORES-1:0] clr_all,
  output logic [NUM_CORES*NUM_CORES-1:0] pend_q,
  output logic [NUM_CORES-1:0]           irq_o
);
  localparam int CELLS = NUM_CORES * NUM_CORES;

  // a set in the same cycle overrides a clear of the same cell
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_all) | set_all;
  end

  for (genvar t = 0; t < NUM_CORES; t++) begin : g_irq
    assign irq_o[t] = |pend_q[t*NUM_CORES +: NUM_CORES];
  end

  logic unused_cells;
  assign unused_cells = (CELLS == 0);

endmodule

// File: rtl/ipi_readback.sv
module ipi_readback #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CORES*NUM_CORES-1:0] pend_q,
  input  logic                           status_hit,
  input  logic                           source_hit,
  input  logic [NUM_CORES-1:0]           issuer_oh,
  input  logic [NUM_CORES-1:0]           param_oh,
  output logic [DATA_W-1:0]              rb_q
);
  logic                 row_any;
  logic [NUM_CORES-1:0] own_row;

  always_comb begin
    row_any = 1'b0;
    own_row = '0;
    for (int t = 0; t < NUM_CORES; t++) begin
      row_any = row_any | (param_oh[t] & (|pend_q[t*NUM_CORES +: NUM_CORES]));
      if (issuer_oh[t]) own_row = pend_q[t*NUM_CORES +: NUM_CORES];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rb_q <= '0;
    else if (status_hit) rb_q <= DATA_W'(row_any);
    else if (source_hit) rb_q <= DATA_W'(own_row);
  end

endmodule

// File: rtl/ipi_unit.sv
module ipi_unit #(
  parameter int NUM_CORES = 4,
  parameter int NUM_PORTS = 2,
  parameter int ID_W      = 4,
  parameter int PARAM_W   = 16,
  parameter int DATA_W    = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PORTS-1:0]           cmd_valid,
  input  logic [NUM_PORTS*8-1:0]         cmd_op,
  input  logic [NUM_PORTS*ID_W-1:0]      cmd_core,
  input  logic [NUM_PORTS*PARAM_W-1:0]   cmd_param,
  output logic [NUM_PORTS*DATA_W-1:0]    rdback,
  output logic [NUM_CORES-1:0]           irq_o
);
  localparam int CELLS = NUM_CORES * NUM_CORES;

  logic [CELLS-1:0]     set_p [NUM_PORTS];
  logic [CELLS-1:0]     clr_p [NUM_PORTS];
  logic [CELLS-1:0]     set_all, clr_all, pend_q;
  logic [NUM_PORTS-1:0] status_hit, source_hit, rd_evt;
  logic [NUM_CORES-1:0] raise_evt, ack_evt;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [NUM_CORES-1:0] issuer_oh, param_oh;

    ipi_cmd_decode #(.NUM_CORES(NUM_CORES), .ID_W(ID_W), .PARAM_W(PARAM_W)) u_dec (
      .valid      (cmd_valid[p]),
      .op         (cmd_op[p*8 +: 8]),
      .core       (cmd_core[p*ID_W +: ID_W]),
      .param      (cmd_param[p*PARAM_W +: PARAM_W]),
      .set_vec    (set_p[p]),
      .clr_vec    (clr_p[p]),
      .status_hit (status_hit[p]),
      .source_hit (source_hit[p]),
      .issuer_oh  (issuer_oh),
      .param_oh   (param_oh)
    );

    ipi_readback #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_rb (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend_q     (pend_q),
      .status_hit (status_hit[p]),
      .source_hit (source_hit[p]),
      .issuer_oh  (issuer_oh),
      .param_oh   (param_oh),
      .rb_q       (rdback[p*DATA_W +: DATA_W])
    );

    assign rd_evt[p] = status_hit[p] | source_hit[p];
  end

  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      set_all = set_all | set_p[p];
      clr_all = clr_all | clr_p[p];
    end
  end

  // named events per core for the checker
  for (genvar t = 0; t < NUM_CORES; t++) begin : g_evt
    assign raise_evt[t] = |set_all[t*NUM_CORES +: NUM_CORES];
    assign ack_evt[t]   = |clr_all[t*NUM_CORES +: NUM_CORES];
  end

  ipi_pend_matrix #(.NUM_CORES(NUM_CORES)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_all (set_all),
    .clr_all (clr_all),
    .pend_q  (pend_q),
    .irq_o   (irq_o)
  );

endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk #(
  parameter int NUM_CORES = 4,
  parameter int NUM_PORTS = 2,
  parameter int DATA_W    = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_CORES-1:0]           irq_o,
  input logic [NUM_PORTS*DATA_W-1:0]    rdback,
  input logic [NUM_CORES-1:0]           raise_evt,
  input logic [NUM_CORES-1:0]           ack_evt,
  input logic [NUM_CORES*NUM_CORES-1:0] set_all,
  input logic [NUM_CORES*NUM_CORES-1:0] clr_all,
  input logic [NUM_CORES*NUM_CORES-1:0] pend_q,
  input logic [NUM_PORTS-1:0]           rd_evt
);

  for (genvar t = 0; t < NUM_CORES; t++) begin : g_core
    assert_raise_sets_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      raise_evt[t] |=> irq_o[t]);

    assert_no_self_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q[t*NUM_CORES + t]);

    assert_drop_needs_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o[t]) |-> $past(ack_evt[t]));

    for (genvar s = 0; s < NUM_CORES; s++) begin : g_pair
      assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_all[t*NUM_CORES + s] && clr_all[t*NUM_CORES + s]) |=> pend_q[t*NUM_CORES + s]);
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assert_readback_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_evt[p] |=> $stable(rdback[p*DATA_W +: DATA_W]));

    assert_readback_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rdback[p*DATA_W + NUM_CORES +: (DATA_W - NUM_CORES)] == '0);
  end

endmodule

bind ipi_unit ipi_unit_chk #(
  .NUM_CORES (NUM_CORES),
  .NUM_PORTS (NUM_PORTS),
  .DATA_W    (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .rdback    (rdback),
  .raise_evt (raise_evt),
  .ack_evt   (ack_evt),
  .set_all   (set_all),
  .clr_all   (clr_all),
  .pend_q    (pend_q),
  .rd_evt    (rd_evt)
);

// File: tb/ipi_unit_tb.sv
module ipi_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NP = 2;
  localparam int IW = 4;
  localparam int PW = 16;
  localparam int DW = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     cmd_valid = '0;
  logic [NP*8-1:0]   cmd_op = '0;
  logic [NP*IW-1:0]  cmd_core = '0;
  logic [NP*PW-1:0]  cmd_param = '0;
  logic [NP*DW-1:0]  rdback;
  logic [NC-1:0]     irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [NC-1:0] mp [NC];   // mp[target][sender]
  logic [DW-1:0] rbm [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_unit #(.NUM_CORES(NC), .NUM_PORTS(NP), .ID_W(IW), .PARAM_W(PW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_core(cmd_core), .cmd_param(cmd_param), .rdback(rdback), .irq_o(irq_o));

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [NC-1:0] model_irq();
    logic [NC-1:0] r;
    for (int t = 0; t < NC; t++) r[t] = |mp[t];
    return r;
  endfunction

  task automatic drive(input int p, input logic v, input logic [7:0] op,
                       input logic [IW-1:0] c, input logic [PW-1:0] q);
    cmd_valid[p] = v;
    cmd_op[p*8 +: 8] = op;
    cmd_core[p*IW +: IW] = c;
    cmd_param[p*PW +: PW] = q;
  endtask

  // advance one clock, update the model, compare every output
  task automatic cycle(input string req);
    logic [NC-1:0] nxt [NC];
    logic [DW-1:0] rbn [NP];
    nxt = mp;
    rbn = rbm;
    for (int p = 0; p < NP; p++) begin
      int c, q;
      logic [7:0] op;
      c = int'(cmd_core[p*IW +: IW]);
      q = int'(cmd_param[p*PW +: PW]);
      op = cmd_op[p*8 +: 8];
      if (cmd_valid[p] && c < NC) begin
        if (op == 8'h02) rbn[p] = (q < NC) ? DW'(|mp[q]) : '0;
        if (op == 8'h03) rbn[p] = DW'(mp[c]);
        if (op == 8'h04 && q < NC) nxt[c][q] = 1'b0;
      end
    end
    for (int p = 0; p < NP; p++) begin
      int c, q;
      c = int'(cmd_core[p*IW +: IW]);
      q = int'(cmd_param[p*PW +: PW]);
      if (cmd_valid[p] && c < NC && cmd_op[p*8 +: 8] == 8'h01 && q < NC && q != c)
        nxt[q][c] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    mp = nxt;
    rbm = rbn;
    check({req, " irq"}, DW'(irq_o), DW'(model_irq()));
    for (int p = 0; p < NP; p++) check({req, " rdback"}, rdback[p*DW +: DW], rbm[p]);
    cmd_valid = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd4711);
    for (int t = 0; t < NC; t++) mp[t] = '0;
    for (int p = 0; p < NP; p++) rbm[p] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", DW'(irq_o), '0);
    check("R1 rdback0", rdback[0 +: DW], '0);
    check("R1 rdback1", rdback[DW +: DW], '0);

    // R2 core0 raises core1
    drive(0, 1, 8'h01, 4'd0, 16'd1); cycle("R2");
    check("R2 irq1", DW'(irq_o), 32'h2);

    // R3 core2 raises itself
    drive(0, 1, 8'h01, 4'd2, 16'd2); cycle("R3");
    check("R3 no self irq", DW'(irq_o), 32'h2);

    // R4 core3 also raises core1, then core1 reads its sources
    drive(1, 1, 8'h01, 4'd3, 16'd1); cycle("R4");
    check("R4 single line", DW'(irq_o), 32'h2);
    drive(1, 1, 8'h03, 4'd1, 16'd0); cycle("R6");
    check("R6 source mask", rdback[DW +: DW], 32'h9);

    // R5 status queries
    drive(0, 1, 8'h02, 4'd0, 16'd1); cycle("R5");
    check("R5 status pending", rdback[0 +: DW], 32'h1);
    drive(0, 1, 8'h02, 4'd0, 16'd2); cycle("R5");
    check("R5 status idle", rdback[0 +: DW], 32'h0);

    // R8 port1 keeps its value while port0 reads and idle cycles pass
    drive(0, 1, 8'h02, 4'd2, 16'd1); cycle("R8");
    cycle("R8"); cycle("R8");
    check("R8 port1 hold", rdback[DW +: DW], 32'h9);
    check("R8 port0 hold", rdback[0 +: DW], 32'h1);

    // R7 partial and full acknowledge
    drive(0, 1, 8'h04, 4'd1, 16'd0); cycle("R7");
    check("R7 still high", DW'(irq_o), 32'h2);
    drive(0, 1, 8'h03, 4'd1, 16'd0); cycle("R7");
    check("R7 one sender left", rdback[0 +: DW], 32'h8);
    drive(0, 1, 8'h04, 4'd1, 16'd3); cycle("R7");
    check("R7 cleared", DW'(irq_o), 32'h0);

    // R9 raise and ack same pair, bit clear before
    drive(0, 1, 8'h01, 4'd0, 16'd2);
    drive(1, 1, 8'h04, 4'd2, 16'd0); cycle("R9");
    check("R9 set wins clear", DW'(irq_o), 32'h4);
    // R9 again with bit already set
    drive(0, 1, 8'h01, 4'd0, 16'd2);
    drive(1, 1, 8'h04, 4'd2, 16'd0); cycle("R9");
    check("R9 set wins held", DW'(irq_o), 32'h4);
    drive(1, 1, 8'h04, 4'd2, 16'd0); cycle("R9");
    check("R9 ack after", DW'(irq_o), 32'h0);

    // R10 out-of-range and unknown commands
    drive(0, 1, 8'h01, 4'd9, 16'd1); cycle("R10");
    check("R10 bad core", DW'(irq_o), 32'h0);
    drive(0, 1, 8'h01, 4'd0, 16'hFFFF); cycle("R10");
    check("R10 bad target", DW'(irq_o), 32'h0);
    drive(0, 1, 8'h3C, 4'd0, 16'd1); cycle("R10");
    check("R10 bad opcode", DW'(irq_o), 32'h0);
    drive(1, 1, 8'h02, 4'd9, 16'd0); cycle("R10");
    check("R10 bad core no readback", rdback[DW +: DW], 32'h9);
    drive(1, 1, 8'h02, 4'd0, 16'h0010); cycle("R10");
    check("R10 status out of range", rdback[DW +: DW], 32'h0);

    // random mix against the model (R2 R4 R5 R6 R7 R8 R9 R10)
    for (int n = 0; n < 600; n++) begin
      for (int p = 0; p < NP; p++) begin
        logic [7:0] op;
        logic [IW-1:0] c;
        logic [PW-1:0] q;
        int k;
        k = $urandom % 12;
        op = (k < 4) ? 8'h01 : (k < 6) ? 8'h02 : (k < 8) ? 8'h03 :
             (k < 11) ? 8'h04 : 8'h3C;
        c = ($urandom % 10 == 0) ? IW'(9) : IW'($urandom % NC);
        q = ($urandom % 10 == 0) ? 16'hFFFF : PW'($urandom % NC);
        drive(p, 1'($urandom % 4 != 0), op, c, q);
      end
      cycle("R4/R7 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule